// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of sixteen general-purpose I/O pins behind a small 16-bit register interface. Software sets each pin's direction and output value, picks an alternate-function select per pin, and reads back the live input levels. Every input goes through a two-flop synchronizer. The synchronized value is then tested against a per-pin trigger condition: a rising edge, a falling edge, a high level or a low level.

A pin whose condition holds while its mask bit is clear latches a sticky bit in the interrupt status register. The bank raises one summary interrupt line while any latched bit is set. Software clears all latched bits at once by writing zero to the status register. Both-edge detection is done by software: after each event it flips the pin's polarity bit, and the detector uses the new polarity from the next sample on.

The register file is word-addressed. The byte offset is the word index times four. Reads are combinational from the address. A write takes effect on the clock edge where the write enable is high.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the interrupt mask register (offset 0x0C) reads 0xFFFF. The direction (0x00), output (0x04), alternate-function (0x20), trigger-type (0x10), edge-polarity (0x14), level-polarity (0x18) and interrupt-status (0x1C) registers read 0x0000, and `irqOut` is low.
- R2: The direction, output and alternate-function registers read back what was written. `pinOe` follows direction (1 = output, 0 = input), `pinOut` follows the output register, and `altSel` follows the alternate-function register.
- R3: Offset 0x08 returns the synchronized input level of each pin. A change made between clock edges shows up after the second rising edge and not after the first. Writes to 0x08 have no effect.
- R4: Each pin's trigger is set by three bits: trigger-type bit (1 = level, 0 = edge), edge bit (1 = rising, 0 = falling) and level bit (1 = high, 0 = low).
- R5: In edge mode, an edge is detected by comparing the current synchronized sample with the previous one. The status bit sets on the third rising clock edge after the input change. The opposite edge does not set it.
- R6: In level mode the status bit sets while the synchronized level matches the level bit. While the level still holds, a clear does not take effect, because a new event in the same cycle wins over the clear.
- R7: A mask bit of 1 blocks its pin. Events on a masked pin never latch, and unmasking later does not raise an edge that happened while masked. Setting a mask bit does not clear a bit that is already latched.
- R8: Interrupt-status bits are sticky. Writing 0x0000 to offset 0x1C clears all of them. Writing any nonzero value there has no effect.
- R9: `irqOut` is high exactly when at least one interrupt-status bit is set.
- R10: A write to the edge-polarity register takes effect from the next sample. After the bit is flipped to falling, a rising edge is ignored and the following falling edge latches.
- R11: Only offsets that are multiples of four from 0x00 to 0x20 are decoded. Any other offset reads 0x0000, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 6 | Byte offset of the register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| pinIn | input | 16 | Asynchronous pin input levels |
| pinOut | output | 16 | Output data to the pads |
| pinOe | output | 16 | Output enable per pin (1 = output) |
| altSel | output | 16 | Alternate-function select per pin |
| irqOut | output | 1 | Summary interrupt |

## Verification
The assertions assume the following about the inputs:
- `regWrEn` and `regAddr` are stable across each clock edge, and at most one register is written per cycle.
- Pin inputs may change at any time, but the edge checks only look at synchronized samples.

The stimulus drives every input on the falling clock edge, so it stays within these assumptions. It changes a pin only after the previous change has passed through the synchronizer and the detector. The expected status can then be tied to a known rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // word indices; byte offset = index * 4
  localparam int unsigned IDX_DIR   = 0;
  localparam int unsigned IDX_OUT   = 1;
  localparam int unsigned IDX_LVLIN = 2;
  localparam int unsigned IDX_MASK  = 3;
  localparam int unsigned IDX_TRIG  = 4;
  localparam int unsigned IDX_EDGE  = 5;
  localparam int unsigned IDX_LPOL  = 6;
  localparam int unsigned IDX_STAT  = 7;
  localparam int unsigned IDX_ALT   = 8;
  localparam int unsigned IDX_LAST  = IDX_ALT;

  typedef enum logic [3:0] {
    RD_DIR, RD_OUT, RD_LVLIN, RD_MASK, RD_TRIG,
    RD_EDGE, RD_LPOL, RD_STAT, RD_ALT, RD_NONE
  } rd_sel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrOut;
    logic    wrMask;
    logic    wrTrig;
    logic    wrEdge;
    logic    wrLpol;
    logic    wrAlt;
    logic    clrStat;
    rd_sel_e rdSel;
  } gpio_strb_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output gpio_strb_t        strb
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             inRange;
  logic             hit;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[ADDR_W-1:2];
  assign inRange = (int'(wordIdx) <= int'(IDX_LAST));
  assign hit     = aligned && inRange;

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    if (hit) begin
      strb.rdSel = rd_sel_e'(wordIdx);
    end
    if (regWrEn && hit) begin
      case (int'(wordIdx))
        IDX_DIR:  strb.wrDir  = 1'b1;
        IDX_OUT:  strb.wrOut  = 1'b1;
        IDX_MASK: strb.wrMask = 1'b1;
        IDX_TRIG: strb.wrTrig = 1'b1;
        IDX_EDGE: strb.wrEdge = 1'b1;
        IDX_LPOL: strb.wrLpol = 1'b1;
        IDX_ALT:  strb.wrAlt  = 1'b1;
        IDX_STAT: strb.clrStat = (regWrData == '0);
        default:  ;
      endcase
    end
  end

  logic [7:0] wrVec;
  assign wrVec = {strb.wrDir, strb.wrOut, strb.wrMask, strb.wrTrig,
                  strb.wrEdge, strb.wrLpol, strb.wrAlt, strb.clrStat};

  assert_wr_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  assert_no_wr_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn || !aligned) |-> (wrVec == '0));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpio_strb_t          strb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] altSel,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] dirReg, outReg, altReg, maskReg;
  logic [NUM_PINS-1:0] trigReg, edgeReg, lpolReg, statReg;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinNow, prevQ;
  logic [NUM_PINS-1:0] hitVec, evtVec;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      altReg  <= '0;
      maskReg <= '1;
      trigReg <= '0;
      edgeReg <= '0;
      lpolReg <= '0;
    end else begin
      if (strb.wrDir)  dirReg  <= wrData;
      if (strb.wrOut)  outReg  <= wrData;
      if (strb.wrAlt)  altReg  <= wrData;
      if (strb.wrMask) maskReg <= wrData;
      if (strb.wrTrig) trigReg <= wrData;
      if (strb.wrEdge) edgeReg <= wrData;
      if (strb.wrLpol) lpolReg <= wrData;
    end
  end

  // input synchronizer and previous-sample register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  // per-pin trigger evaluation
  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic riseHit, fallHit, edgeHit, levelHit;
    assign riseHit  = pinNow[g] & ~prevQ[g];
    assign fallHit  = ~pinNow[g] & prevQ[g];
    assign edgeHit  = edgeReg[g] ? riseHit : fallHit;
    assign levelHit = lpolReg[g] ? pinNow[g] : ~pinNow[g];
    assign hitVec[g] = trigReg[g] ? levelHit : edgeHit;
  end

  assign evtVec = hitVec & ~maskReg;

  // sticky status; a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= (strb.clrStat ? '0 : statReg) | evtVec;
  end

  assign irqOut = |statReg;
  assign pinOut = outReg;
  assign pinOe  = dirReg;
  assign altSel = altReg;

  always_comb begin
    case (strb.rdSel)
      RD_DIR:   rdData = dirReg;
      RD_OUT:   rdData = outReg;
      RD_LVLIN: rdData = pinNow;
      RD_MASK:  rdData = maskReg;
      RD_TRIG:  rdData = trigReg;
      RD_EDGE:  rdData = edgeReg;
      RD_LPOL:  rdData = lpolReg;
      RD_STAT:  rdData = statReg;
      RD_ALT:   rdData = altReg;
      default:  rdData = '0;
    endcase
  end

  logic clrQ;
  always_ff @(posedge clk) begin
    if (!rstN) clrQ <= 1'b0;
    else       clrQ <= strb.clrStat;
  end

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & $past(maskReg)) == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clrQ |-> ((statReg & $past(statReg)) == $past(statReg)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStat && (evtVec == '0)) |=> (statReg == '0));

  assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec & ~trigReg & ~(pinNow ^ prevQ)) == '0);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(evtVec != '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] altSel,
  output logic                irqOut
);

  gpio_strb_t strb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .pinIn(pinIn), .rdData(regRdData), .pinOut(pinOut), .pinOe(pinOe),
    .altSel(altSel), .irqOut(irqOut)
  );

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_DIR = 6'h00, A_OUT = 6'h04, A_LVL = 6'h08,
    A_MASK = 6'h0C, A_TRIG = 6'h10, A_EDGE = 6'h14, A_LPOL = 6'h18,
    A_STAT = 6'h1C, A_ALT = 6'h20;

  // kinds: 0 register read, 1 irq, 2 pinOe, 3 pinOut, 4 altSel
  typedef struct {
    int          kind;
    logic [5:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData, pinOut, pinOe, altSel;
  logic [15:0] pinIn = '0;
  logic        irqOut;

  item_t expQ[$];
  event  smpEv;
  int    nTests = 0;
  int    nFail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .altSel(altSel), .irqOut(irqOut)
  );

  // monitor: pop and compare
  initial begin
    forever begin
      @(smpEv);
      while (expQ.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0: act = regRdData;
          1: act = {15'b0, irqOut};
          2: act = pinOe;
          3: act = pinOut;
          default: act = altSel;
        endcase
        nTests++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [5:0] a,
                      input logic [15:0] e, input string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    if (kind == 0) regAddr = a;
    expQ.push_back(it);
    #1 -> smpEv;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    push(0, a, e, tag);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    push(1, '0, {15'b0, e}, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setPin(input logic [15:0] v, input int waitEdges);
    @(negedge clk);
    pinIn = v;
    repeat (waitEdges) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    rd(A_MASK, 16'hFFFF, "R1 mask");
    rd(A_DIR,  16'h0000, "R1 dir");
    rd(A_OUT,  16'h0000, "R1 out");
    rd(A_ALT,  16'h0000, "R1 alt");
    rd(A_TRIG, 16'h0000, "R1 trig");
    rd(A_EDGE, 16'h0000, "R1 edge");
    rd(A_LPOL, 16'h0000, "R1 lpol");
    rd(A_STAT, 16'h0000, "R1 stat");
    chkIrq(1'b0, "R1 irq");

    // plain registers
    wr(A_DIR, 16'hA5A5); wr(A_OUT, 16'h3C3C); wr(A_ALT, 16'h0F0F);
    rd(A_DIR, 16'hA5A5, "R2 dir");
    rd(A_OUT, 16'h3C3C, "R2 out");
    rd(A_ALT, 16'h0F0F, "R2 alt");
    push(2, '0, 16'hA5A5, "R2 pinOe");
    push(3, '0, 16'h3C3C, "R2 pinOut");
    push(4, '0, 16'h0F0F, "R2 altSel");

    // decode holes
    wr(6'h06, 16'hFFFF); wr(6'h24, 16'hFFFF);
    rd(6'h24, 16'h0000, "R11 read 0x24");
    rd(6'h06, 16'h0000, "R11 read 0x06");
    rd(A_OUT, 16'h3C3C, "R11 out unchanged");
    rd(A_MASK, 16'hFFFF, "R11 mask unchanged");

    // synchronized level
    @(negedge clk); pinIn = 16'h0001;
    @(negedge clk); rd(A_LVL, 16'h0000, "R3 one edge");
    @(negedge clk); rd(A_LVL, 16'h0001, "R3 two edges");
    wr(A_LVL, 16'hFFFF);
    rd(A_LVL, 16'h0001, "R3 write ignored");
    rd(A_STAT, 16'h0000, "R7 masked pin0 no latch");

    // rising edge on pin1
    wr(A_EDGE, 16'h0002); wr(A_MASK, 16'hFFFD);
    rd(A_EDGE, 16'h0002, "R4 edge reg");
    @(negedge clk); pinIn = 16'h0003;
    @(negedge clk); rd(A_STAT, 16'h0000, "R5 after edge 1");
    @(negedge clk); rd(A_STAT, 16'h0000, "R5 after edge 2");
    @(negedge clk); rd(A_STAT, 16'h0002, "R5 after edge 3");
    chkIrq(1'b1, "R9 irq high");

    // clear semantics
    wr(A_STAT, 16'h1234);
    rd(A_STAT, 16'h0002, "R8 nonzero write ignored");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R8 zero clears");
    chkIrq(1'b0, "R9 irq low");

    // falling edge ignored in rising mode
    setPin(16'h0001, 4);
    rd(A_STAT, 16'h0000, "R5 opposite edge ignored");

    // polarity flip
    wr(A_EDGE, 16'h0000);
    setPin(16'h0003, 4);
    rd(A_STAT, 16'h0000, "R10 rising ignored after flip");
    setPin(16'h0001, 4);
    rd(A_STAT, 16'h0002, "R10 falling latched after flip");
    wr(A_STAT, 16'h0000);
    wr(A_EDGE, 16'h0002);
    setPin(16'h0003, 4);
    rd(A_STAT, 16'h0002, "R10 rising after flip back");
    wr(A_STAT, 16'h0000);

    // level high on pin2
    wr(A_TRIG, 16'h0004); wr(A_LPOL, 16'h0004); wr(A_MASK, 16'hFFF9);
    rd(A_STAT, 16'h0000, "R6 level not met");
    setPin(16'h0007, 3);
    rd(A_STAT, 16'h0004, "R6 level high latched");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0004, "R6 clear loses to held level");
    setPin(16'h0003, 3);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R6 clear after level drops");

    // mask behaviour on pin3
    wr(A_EDGE, 16'h000A);
    setPin(16'h000B, 4);
    rd(A_STAT, 16'h0000, "R7 masked edge");
    chkIrq(1'b0, "R7 irq low masked");
    wr(A_MASK, 16'hFFF1);
    rd(A_STAT, 16'h0000, "R7 unmask no stale event");
    setPin(16'h0003, 4);
    setPin(16'h000B, 4);
    rd(A_STAT, 16'h0008, "R7 unmasked edge latched");
    wr(A_MASK, 16'hFFF9);
    rd(A_MASK, 16'hFFF9, "R7 mask readback");
    rd(A_STAT, 16'h0008, "R7 mask keeps latched bit");
    chkIrq(1'b1, "R9 irq held");
    wr(A_STAT, 16'h0000);
    chkIrq(1'b0, "R9 irq after clear");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule